// File: doc/BRIEF.md
# Transition-Compressed Logic Capture Engine

This block records the activity of a wide bus of logic inputs into on-chip capture memory. The inputs are sampled on every clock. In compressed mode, a record is stored only when the sampled bus differs from the last stored state. Each record pairs the new bus state with the number of cycles since the previous record. Because only the gap between records is kept, and never an absolute time, a narrow counter can cover a capture of any length.

Records go into two memories that share one write address. The state memory holds the bus value. The timestamp memory holds a delta count and a one-bit record type. Some records need no state word. If the previous record changed exactly one bit and that same bit flips again, only the time and a type flag are written, and the reader infers the toggle. If the delta counter is about to saturate while the bus is idle, the engine stores a filler record. A raw mode stores the bus on every clock without timing. After capture stops, a host unloads the records through a read port with one cycle of latency.

Top module: `tcap_engine`

## Requirements
- R1: In compressed mode, after the first record, a record is stored only in a cycle where the inputs differ from the last stored state, or as a filler record (R6).
- R2: For a full record, the state word and the timestamp word are written in the same cycle at the same address. `cap_count_o` equals the number of records stored since start.
- R3: The delta of a record is the number of clock cycles since the previous record. The first record after start holds the sampled bus with delta 0 and type 0.
- R4: When the inputs change on every cycle, a record is stored on every cycle, each with delta 1.
- R5: If the previous record changed exactly one bit and that same single bit changes now, the record has type 1 (`rd_type_o` = 1, the timestamp word's top bit). Its state entry is not written. Every other record has type 0.
- R6: After 2^DW-1 cycles with no change since the last record, a filler record is stored. It has type 0, the unchanged state and delta 2^DW-1. Counting then restarts, and a filler never counts as a single-bit change for R5.
- R7: If `raw_mode_i` is high at start, one state word is stored on every clock and the timestamp memory is not written.
- R8: When the count reaches DEPTH, capture stops, `full_o` goes to 1, and the count holds at DEPTH until the next start.
- R9: `rd_en_i` while stopped gives `rd_valid_o` = 1 on the next cycle, together with the state, delta and type stored at `rd_addr_i`. While capture runs, `rd_en_i` is ignored and `rd_valid_o` stays 0.
- R10: After reset, the count is 0 and `full_o` and `rd_valid_o` are 0. `start_i` while stopped clears the count and `full_o`, and sampling begins on the next cycle. `start_i` while running is ignored. `stop_i` while running halts capture, and no record is stored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a capture (when stopped) |
| stop_i | input | 1 | End a capture (when running) |
| raw_mode_i | input | 1 | Mode latched at start: 1 raw, 0 compressed |
| chan_i | input | CH | Sampled logic inputs |
| full_o | output | 1 | Memory filled, capture ended |
| cap_count_o | output | AW+1 | Records stored since start |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | AW | Read address |
| rd_valid_o | output | 1 | Read data valid (one cycle after request) |
| rd_state_o | output | CH | Stored state |
| rd_delta_o | output | DW | Stored delta |
| rd_type_o | output | 1 | 0 full record, 1 repeat-toggle record |

## Verification
The assertions check several properties on every cycle. The count never exceeds DEPTH and is stable in cycles with no write. The delta counter stays below saturation. A repeat-toggle record never writes the state memory. Raw mode writes on every running cycle. `full_o` implies capture has stopped. Reads are refused while capture runs. Only the bench's scenarios can show that the stored deltas, types, filler placement and unloaded values match the input history. The reference model replays that history and compares every cycle and every unloaded record.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    // Kind of record chosen for the current cycle
    typedef enum logic [2:0] {
        REC_NONE   = 3'd0,
        REC_FULL   = 3'd1,
        REC_TOGGLE = 3'd2,
        REC_FILLER = 3'd3,
        REC_RAW    = 3'd4
    } rec_kind_e;
endpackage

// File: rtl/tcap_change_det.sv
module tcap_change_det #(
    parameter int CH = 34
) (
    input  logic [CH-1:0] sample_i,
    input  logic [CH-1:0] last_i,
    input  logic [CH-1:0] prev_mask_i,
    output logic [CH-1:0] diff_o,
    output logic          changed_o,
    output logic          repeat_o
);
    always_comb begin
        diff_o    = sample_i ^ last_i;
        changed_o = |diff_o;
        // same single bit flipped as in the previous record
        repeat_o  = changed_o && $onehot(diff_o) && (diff_o == prev_mask_i);
    end
endmodule

// File: rtl/tcap_mem.sv
module tcap_mem #(
    parameter int W     = 34,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_o <= mem_q[raddr_i];
        end
    end
endmodule

// File: rtl/tcap_engine.sv
module tcap_engine
    import tcap_pkg::*;
#(
    parameter int CH    = 34,
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          raw_mode_i,
    input  logic [CH-1:0] chan_i,
    output logic          full_o,
    output logic [AW:0]   cap_count_o,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic          rd_valid_o,
    output logic [CH-1:0] rd_state_o,
    output logic [DW-1:0] rd_delta_o,
    output logic          rd_type_o
);
    localparam logic [DW-1:0] MAXD      = '1;
    localparam logic [AW:0]   LAST_ADDR = (AW+1)'(DEPTH - 1);
    localparam int            TSW       = DW + 1;

    typedef struct packed {
        logic          run;
        logic          full;
        logic          raw;
        logic          first;
        logic          rvalid;
        logic [AW:0]   addr;
        logic [CH-1:0] last;
        logic [CH-1:0] pmask;
        logic [DW-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic [CH-1:0]  diff;
    logic           changed;
    logic           rep_hit;
    rec_kind_e      kind;
    logic           st_we;
    logic           ts_we;
    logic [TSW-1:0] ts_wdata;
    logic [TSW-1:0] ts_rdata;
    logic           rd_ok;

    tcap_change_det #(.CH(CH)) i_det (
        .sample_i   (chan_i),
        .last_i     (r_q.last),
        .prev_mask_i(r_q.pmask),
        .diff_o     (diff),
        .changed_o  (changed),
        .repeat_o   (rep_hit)
    );

    always_comb begin
        r_d      = r_q;
        kind     = REC_NONE;
        st_we    = 1'b0;
        ts_we    = 1'b0;
        ts_wdata = '0;
        rd_ok    = rd_en_i && !r_q.run;
        r_d.rvalid = rd_ok;

        if (!r_q.run) begin
            if (start_i) begin
                r_d.run   = 1'b1;
                r_d.full  = 1'b0;
                r_d.raw   = raw_mode_i;
                r_d.first = 1'b1;
                r_d.addr  = '0;
                r_d.cnt   = '0;
                r_d.pmask = '0;
            end
        end else if (stop_i) begin
            r_d.run = 1'b0;
        end else begin
            if (r_q.raw) begin
                kind = REC_RAW;
            end else if (r_q.first) begin
                kind = REC_FULL;
            end else if (changed) begin
                kind = rep_hit ? REC_TOGGLE : REC_FULL;
            end else if (r_q.cnt == MAXD - 1'b1) begin
                kind = REC_FILLER;
            end

            unique case (kind)
                REC_RAW: begin
                    st_we = 1'b1;
                end
                REC_FULL: begin
                    st_we    = 1'b1;
                    ts_we    = 1'b1;
                    ts_wdata = {1'b0, (r_q.first ? '0 : r_q.cnt + 1'b1)};
                end
                REC_TOGGLE: begin
                    ts_we    = 1'b1;
                    ts_wdata = {1'b1, r_q.cnt + 1'b1};
                end
                REC_FILLER: begin
                    st_we    = 1'b1;
                    ts_we    = 1'b1;
                    ts_wdata = {1'b0, MAXD};
                end
                default: ;
            endcase

            if (kind != REC_NONE) begin
                r_d.addr  = r_q.addr + 1'b1;
                r_d.last  = chan_i;
                r_d.cnt   = '0;
                r_d.first = 1'b0;
                r_d.pmask = (kind == REC_FULL && !r_q.first) || kind == REC_TOGGLE ? diff : '0;
                if (r_q.addr == LAST_ADDR) begin
                    r_d.run  = 1'b0;
                    r_d.full = 1'b1;
                end
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    tcap_mem #(.W(CH), .DEPTH(DEPTH)) i_state_mem (
        .clk    (clk),
        .we_i   (st_we),
        .waddr_i(r_q.addr[AW-1:0]),
        .wdata_i(chan_i),
        .re_i   (rd_ok),
        .raddr_i(rd_addr_i),
        .rdata_o(rd_state_o)
    );

    tcap_mem #(.W(TSW), .DEPTH(DEPTH)) i_time_mem (
        .clk    (clk),
        .we_i   (ts_we),
        .waddr_i(r_q.addr[AW-1:0]),
        .wdata_i(ts_wdata),
        .re_i   (rd_ok),
        .raddr_i(rd_addr_i),
        .rdata_o(ts_rdata)
    );

    assign full_o      = r_q.full;
    assign cap_count_o = r_q.addr;
    assign rd_valid_o  = r_q.rvalid;
    assign rd_delta_o  = ts_rdata[DW-1:0];
    assign rd_type_o   = ts_rdata[DW];

    // R8: count never passes the memory depth
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cap_count_o <= (AW+1)'(DEPTH));
    // R8: a full memory means capture has ended
    a_r8_full_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !r_q.run);
    // R2: count moves only when a memory is written
    a_r2_count_tracks_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.run && !stop_i && !st_we && !ts_we) |=> $stable(cap_count_o));
    // R5: a repeat-toggle record leaves the state memory alone
    a_r5_toggle_no_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_we && ts_wdata[DW]) |-> !st_we);
    // R6: the gap counter never reaches saturation
    a_r6_cnt_below_max: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt != MAXD);
    // R7: raw capture writes state on every running cycle, no timestamp
    a_r7_raw_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.run && r_q.raw && !stop_i) |-> (st_we && !ts_we));
    // R9: no read data while capture runs
    a_r9_no_read_running: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && r_q.run) |=> !rd_valid_o);
    // R10: start while stopped clears the count
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !r_q.run) |=> (cap_count_o == '0 && !full_o));
endmodule

// File: tb/test_tcap_engine.sv
module test_tcap_engine;
    localparam int CH    = 34;
    localparam int DW    = 4;
    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam int MAXD  = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, stop_i = 1'b0, raw_mode_i = 1'b0, rd_en_i = 1'b0;
    logic [CH-1:0] chan_i = '0;
    logic [AW-1:0] rd_addr_i = '0;
    logic          full_o, rd_valid_o, rd_type_o;
    logic [AW:0]   cap_count_o;
    logic [CH-1:0] rd_state_o;
    logic [DW-1:0] rd_delta_o;

    always #4 clk = ~clk;

    tcap_engine #(.CH(CH), .DW(DW), .DEPTH(DEPTH)) i_tcap_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .raw_mode_i(raw_mode_i), .chan_i(chan_i), .full_o(full_o),
        .cap_count_o(cap_count_o), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_valid_o(rd_valid_o), .rd_state_o(rd_state_o),
        .rd_delta_o(rd_delta_o), .rd_type_o(rd_type_o)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string cur_tag = "R10";

    // reference model
    bit            m_run, m_full, m_raw, m_first, m_rv;
    int            m_count, m_cnt, m_ra;
    logic [CH-1:0] m_last, m_pmask;
    logic [CH-1:0] e_state [DEPTH];
    int            e_delta [DEPTH];
    int            e_type  [DEPTH];
    bit            e_raw   [DEPTH];
    string         e_tag   [DEPTH];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic store(input logic [CH-1:0] st, input int dl, input int ty, input bit rw, input string tag);
        e_state[m_count] = st;
        e_delta[m_count] = dl;
        e_type[m_count]  = ty;
        e_raw[m_count]   = rw;
        e_tag[m_count]   = tag;
        m_count++;
        m_cnt  = 0;
        m_last = st;
        m_first = 0;
        if (m_count == DEPTH) begin
            m_run  = 0;
            m_full = 1;
        end
    endtask

    task automatic cyc(input bit st, input bit sp, input bit rw, input logic [CH-1:0] ch,
                       input bit re, input int ra);
        logic [CH-1:0] diff;
        bit nrv;
        @(negedge clk);
        chk(cur_tag, 64'(cap_count_o), 64'(m_count));
        chk("R8 full", 64'(full_o), 64'(m_full));
        chk("R9 valid", 64'(rd_valid_o), 64'(m_rv));
        if (m_rv && rd_valid_o) begin
            if (e_raw[m_ra]) begin
                chk("R7 raw state", 64'(rd_state_o), 64'(e_state[m_ra]));
            end else begin
                if (e_type[m_ra] == 0) chk("R2 state", 64'(rd_state_o), 64'(e_state[m_ra]));
                chk(e_tag[m_ra], 64'(rd_delta_o), 64'(e_delta[m_ra]));
                chk("R5 type", 64'(rd_type_o), 64'(e_type[m_ra]));
            end
        end
        start_i = st; stop_i = sp; raw_mode_i = rw; chan_i = ch;
        rd_en_i = re; rd_addr_i = AW'(ra);
        nrv = re && !m_run;
        if (!m_run) begin
            if (st) begin
                m_run = 1; m_full = 0; m_raw = rw; m_first = 1;
                m_count = 0; m_cnt = 0; m_pmask = '0;
            end
        end else if (sp) begin
            m_run = 0;
        end else if (m_raw) begin
            store(ch, 0, 0, 1, "R7");
        end else begin
            diff = ch ^ m_last;
            if (m_first) begin
                m_pmask = '0;
                store(ch, 0, 0, 0, "R3 first");
            end else if (diff != '0) begin
                if ($countones(diff) == 1 && diff == m_pmask) begin
                    store(ch, m_cnt + 1, 1, 0, "R5 delta");
                end else begin
                    store(ch, m_cnt + 1, 0, 0, "R3 delta");
                    m_pmask = diff;
                end
            end else if (m_cnt + 1 == MAXD) begin
                m_pmask = '0;
                store(ch, MAXD, 0, 0, "R6 filler");
            end else begin
                m_cnt++;
            end
        end
        m_rv = nrv; m_ra = ra;
    endtask

    task automatic readback(input int n);
        for (int a = 0; a < n; a++) cyc(0, 0, 0, chan_i, 1, a);
        cyc(0, 0, 0, chan_i, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL R10 watchdog: actual %0d cycles expected under 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [CH-1:0] v;
        m_run = 0; m_full = 0; m_raw = 0; m_first = 0; m_rv = 0;
        m_count = 0; m_cnt = 0; m_ra = 0; m_last = '0; m_pmask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R10 reset";
        cyc(0, 0, 0, '0, 0, 0);

        // compressed capture: R1 R3 R5
        cur_tag = "R1";
        v = 34'h2_0000_00F0;
        cyc(1, 0, 0, v, 0, 0);
        cyc(0, 0, 0, v, 0, 0);
        cyc(0, 0, 0, v, 1, 0);            // R9 read while running ignored
        cyc(0, 0, 0, v, 0, 0);
        v = v ^ 34'h1_0000_0303;
        cyc(0, 0, 0, v, 0, 0);
        cyc(0, 0, 0, v, 0, 0);
        v = v ^ 34'h8; cyc(0, 0, 0, v, 0, 0);
        cyc(0, 0, 0, v, 0, 0);
        v = v ^ 34'h8; cyc(0, 0, 0, v, 0, 0);
        v = v ^ 34'h8; cyc(0, 0, 0, v, 0, 0);
        cyc(1, 0, 0, v, 0, 0);            // R10 start while running ignored
        v = v ^ 34'h10; cyc(0, 0, 0, v, 0, 0);
        v = v ^ 34'h10; cyc(0, 0, 0, v, 0, 0);
        cur_tag = "R4";
        for (int i = 0; i < 6; i++) begin
            v = v + 34'h3_0000_0001;
            cyc(0, 0, 0, v, 0, 0);
        end
        cur_tag = "R6";
        for (int i = 0; i < 34; i++) cyc(0, 0, 0, v, 0, 0);
        v = v ^ 34'h8; cyc(0, 0, 0, v, 0, 0);
        v = v ^ 34'h8; cyc(0, 0, 0, v, 0, 0);
        cur_tag = "R10 stop";
        v = ~v;
        cyc(0, 1, 0, v, 0, 0);
        cyc(0, 0, 0, v, 0, 0);
        cur_tag = "R9";
        readback(m_count);

        // raw mode: R7
        cur_tag = "R7";
        cyc(1, 0, 1, '0, 0, 0);
        for (int i = 0; i < 7; i++) cyc(0, 0, 0, CH'(i * 5 + 1), 0, 0);
        cyc(0, 0, 0, CH'(7), 0, 0);
        cyc(0, 1, 0, CH'(7), 0, 0);
        cur_tag = "R9";
        readback(m_count);

        // fill: R8
        cur_tag = "R8";
        cyc(1, 0, 0, '0, 0, 0);
        for (int i = 0; i < DEPTH + 6; i++) cyc(0, 0, 0, {CH{i[0]}} ^ CH'(i), 0, 0);
        readback(4);
        cyc(0, 0, 0, '0, 1, DEPTH - 1);
        cyc(0, 0, 0, '0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule